// File: doc/BRIEF.md
# Nonvolatile Memory Control Register

This block is the 8-bit control and status register that sits in front of an on-chip nonvolatile memory controller, together with the small sequencer behind it. The CPU writes and reads the register through a plain single-cycle register port. Stored select bits pick the target space: data EEPROM, program flash or the configuration registers. Two start bits launch operations. One issues a single-cycle read strobe toward the memory model. The other begins a self-timed erase or write cycle, whose length in clock cycles is a parameter.

Both start bits can only be set by software, and hardware clears them. A write cycle can start only while the enable bit is already set. The select and erase bits are frozen while a cycle is running. A warm reset (external or watchdog) that arrives during a self-timed cycle aborts the cycle and raises an error flag. The select and erase bits keep their values, so software can see which operation failed.

The CPU port has no back-pressure, so it has no valid/ready handshake. A write is taken on every clock edge where `reg_we` is high. Read data is a combinational view of the register. The memory-side pins are plain level and strobe signals.

Top module: `nvm_ctl_reg`

## Requirements
- R1: After power-on reset (`por_n` low), the register reads 0x00, `busy` and `mem_rd_pulse` are low, and `mem_space` is 0.
- R2: `mem_space` encodes the target: 2 (configuration) when bit 6 is 1, whatever bit 7 holds; otherwise 1 (program flash) when bit 7 is 1, and 0 (data EEPROM) when bit 7 is 0.
- R3: Bit 5 always reads 0, even after a write of 1 to it.
- R4: A write with bit 0 = 1 that leaves bit 7 at 0 sets bit 0 and raises `mem_rd_pulse` for exactly the one cycle after the write edge. After that, both are 0 again.
- R5: A write with bit 0 = 1 that leaves bit 7 at 1 is ignored: bit 0 stays 0 and `mem_rd_pulse` stays low.
- R6: Writing 0 to bit 1 while a cycle is running does not stop the cycle, and bit 1 still reads 1.
- R7: A write of 1 to bit 1 while the stored bit 2 is 0 starts no cycle and does not set bit 3. This holds even when the same write sets bit 2.
- R8: A write of 1 to bit 1 with bit 2 already set makes `busy` and bit 1 high for exactly CYC_LEN cycles, with `mem_op_start` high only in the first of those cycles. Hardware then clears bit 1.
- R9: If bit 4 is 1 when a cycle starts, `mem_op_erase` is high during the cycle and hardware clears bit 4 when the cycle completes.
- R10: A warm reset during a cycle ends it at once (`busy` low). It sets bit 3, clears bits 2, 1 and 0, and keeps bits 7, 6 and 4.
- R11: A warm reset while idle clears bits 2, 1 and 0, leaves bits 7, 6, 4 and 3 unchanged, and does not set bit 3.
- R12: While a cycle is running, software writes to bits 7, 6 and 4 are ignored. Writes to bits 3 and 2 still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset (external or watchdog), active high |
| reg_we | input | 1 | CPU register write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read view |
| mem_space | output | 2 | Target space: 0 data EEPROM, 1 program flash, 2 configuration |
| mem_rd_pulse | output | 1 | One-cycle read strobe |
| mem_op_start | output | 1 | High in the first cycle of a self-timed cycle |
| mem_op_erase | output | 1 | Current self-timed cycle is a row erase |
| busy | output | 1 | Self-timed cycle in progress |

## Verification
The bench builds the block with CYC_LEN = 6 instead of the long default. This keeps each self-timed cycle short enough to count cycle by cycle. It also leaves enough room inside one cycle to issue a mid-cycle write and still see `busy` afterwards. It also makes it possible to inject a warm reset partway through an erase, and to reach completion several times within one run.

// File: rtl/nvm_ctl_pkg.sv
package nvm_ctl_pkg;
  localparam int unsigned BIT_PRG   = 7;
  localparam int unsigned BIT_CFG   = 6;
  localparam int unsigned BIT_RSV   = 5;
  localparam int unsigned BIT_ERASE = 4;
  localparam int unsigned BIT_ERR   = 3;
  localparam int unsigned BIT_EN    = 2;
  localparam int unsigned BIT_GO    = 1;
  localparam int unsigned BIT_RD    = 0;

  typedef enum logic [1:0] {
    SPACE_DATA = 2'd0,
    SPACE_PROG = 2'd1,
    SPACE_CONF = 2'd2
  } space_e;

  typedef struct packed {
    logic prg;
    logic cfg;
    logic erase;
    logic err;
    logic en;
    logic go;
    logic rd;
  } ctl_fields_t;
endpackage

// File: rtl/nvm_space_decode.sv
module nvm_space_decode
  import nvm_ctl_pkg::*;
(
  input  logic       prg,
  input  logic       cfg,
  output logic [1:0] space
);
  always_comb begin
    if (cfg)      space = SPACE_CONF;
    else if (prg) space = SPACE_PROG;
    else          space = SPACE_DATA;
  end
endmodule

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
  parameter int unsigned CYC_LEN = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic run,
  output logic first,
  output logic done
);
  localparam int unsigned CNT_W = (CYC_LEN > 2) ? $clog2(CYC_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign first = run && (cnt == '0);
  assign done  = run && (cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            cnt <= '0;
    else if (clr || !run)  cnt <= '0;
    else if (done)         cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R8: the count never runs past the programmed cycle length
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!por_n)
    cnt <= LAST);

  // R8: a finished cycle restarts the count
  p_cnt_wrap_r8: assert property (@(posedge clk) disable iff (!por_n)
    (done && !clr) |=> (cnt == '0));
endmodule

// File: rtl/nvm_ctl_bits.sv
module nvm_ctl_bits
  import nvm_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        warm_rst,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  input  logic        cyc_done,
  output ctl_fields_t f
);
  logic busy_now;
  logic prg_after;
  logic set_rd;
  logic set_go;

  assign busy_now  = f.go;
  assign prg_after = (reg_we && !busy_now) ? reg_wdata[BIT_PRG] : f.prg;
  assign set_rd    = reg_we && reg_wdata[BIT_RD] && !prg_after;
  assign set_go    = reg_we && reg_wdata[BIT_GO] && f.en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      f <= '0;
    end else if (warm_rst) begin
      f.err <= f.err | f.go;
      f.go  <= 1'b0;
      f.rd  <= 1'b0;
      f.en  <= 1'b0;
    end else begin
      f.rd <= set_rd;
      if (reg_we) begin
        f.en  <= reg_wdata[BIT_EN];
        f.err <= reg_wdata[BIT_ERR];
        if (!busy_now) begin
          f.prg   <= reg_wdata[BIT_PRG];
          f.cfg   <= reg_wdata[BIT_CFG];
          f.erase <= reg_wdata[BIT_ERASE];
        end
      end
      if (set_go) f.go <= 1'b1;
      if (cyc_done) begin
        f.go <= 1'b0;
        if (f.erase) f.erase <= 1'b0;
      end
    end
  end

  // R4: the read strobe lasts one cycle unless re-armed
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!por_n)
    (f.rd && !(reg_we && reg_wdata[BIT_RD])) |=> !f.rd);

  // R7: no cycle starts without a prior enable
  p_no_start_wo_en_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!f.go && !f.en) |=> !f.go);

  // R10: the error flag only rises from a software write or an aborted cycle
  p_err_source_r10: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(f.err) && !$past(reg_we)) |-> $past(f.go && warm_rst));

  // R12: selection bits are frozen through a running cycle
  p_sel_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
    ($past(f.go) && f.go) |-> ($stable(f.prg) && $stable(f.cfg)));

  // R11: an idle warm reset never raises the error flag
  p_idle_warm_r11: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst && !f.go && !f.err) |=> !f.err);
endmodule

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
  import nvm_ctl_pkg::*;
#(
  parameter int unsigned CYC_LEN = 1000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_rst,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [1:0] mem_space,
  output logic       mem_rd_pulse,
  output logic       mem_op_start,
  output logic       mem_op_erase,
  output logic       busy
);
  ctl_fields_t f;
  logic        cyc_done;
  logic        cyc_first;

  initial begin
    if (CYC_LEN < 2) $error("CYC_LEN must be at least 2");
  end

  nvm_ctl_bits u_bits (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .cyc_done (cyc_done),
    .f        (f)
  );

  nvm_cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
    .clk  (clk),
    .por_n(por_n),
    .clr  (warm_rst),
    .run  (f.go),
    .first(cyc_first),
    .done (cyc_done)
  );

  nvm_space_decode u_dec (
    .prg  (f.prg),
    .cfg  (f.cfg),
    .space(mem_space)
  );

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[BIT_PRG]   = f.prg;
    reg_rdata[BIT_CFG]   = f.cfg;
    reg_rdata[BIT_RSV]   = 1'b0;
    reg_rdata[BIT_ERASE] = f.erase;
    reg_rdata[BIT_ERR]   = f.err;
    reg_rdata[BIT_EN]    = f.en;
    reg_rdata[BIT_GO]    = f.go;
    reg_rdata[BIT_RD]    = f.rd;
  end

  assign busy         = f.go;
  assign mem_rd_pulse = f.rd;
  assign mem_op_start = cyc_first;
  assign mem_op_erase = f.erase && f.go;

  // R8: the start marker appears only on the first busy cycle
  p_start_edge_r8: assert property (@(posedge clk) disable iff (!por_n)
    mem_op_start |-> (busy && !$past(busy)));

  // R2: a configuration select always wins the decode
  p_cfg_wins_r2: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[BIT_CFG] |-> (mem_space == SPACE_CONF));

  // R10: a warm reset always drops busy on the next cycle
  p_warm_stop_r10: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> !busy);
endmodule

// File: tb/sim_nvm_ctl_reg.sv
module sim_nvm_ctl_reg;
  localparam int unsigned CL = 6;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] mem_space;
  logic       mem_rd_pulse, mem_op_start, mem_op_erase, busy;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nvm_ctl_reg #(.CYC_LEN(CL)) u0 (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_space(mem_space), .mem_rd_pulse(mem_rd_pulse),
    .mem_op_start(mem_op_start), .mem_op_erase(mem_op_erase), .busy(busy)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic warm();
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "rdata", reg_rdata, 8'h00);
    chk("R1", "busy", busy, 0);
    chk("R1", "rd_pulse", mem_rd_pulse, 0);
    chk("R1", "space", mem_space, 0);
  endtask

  task automatic t_space();
    wr(8'h80); chk("R2", "space prog", mem_space, 1);
    wr(8'hC0); chk("R2", "space cfg over prog", mem_space, 2);
    wr(8'h40); chk("R2", "space cfg", mem_space, 2);
    wr(8'h20); chk("R3", "bit5 reads 0", reg_rdata, 8'h00);
    chk("R2", "space data", mem_space, 0);
  endtask

  task automatic t_read();
    wr(8'h01);
    chk("R4", "rd pulse high", mem_rd_pulse, 1);
    chk("R4", "rd bit set", reg_rdata, 8'h01);
    @(negedge clk);
    chk("R4", "rd pulse gone", mem_rd_pulse, 0);
    chk("R4", "rd bit cleared", reg_rdata, 8'h00);
    wr(8'h81);
    chk("R5", "rd blocked pulse", mem_rd_pulse, 0);
    chk("R5", "rd blocked bit", reg_rdata, 8'h80);
  endtask

  task automatic t_gate();
    wr(8'h02);
    chk("R7", "no start busy", busy, 0);
    chk("R7", "no start rdata", reg_rdata, 8'h00);
    wr(8'h06);
    chk("R7", "same-write enable no start", busy, 0);
    chk("R7", "enable only", reg_rdata, 8'h04);
  endtask

  task automatic t_cycle();
    int n = 1;
    wr(8'h06);
    chk("R8", "busy", busy, 1);
    chk("R8", "start", mem_op_start, 1);
    chk("R8", "go bit", reg_rdata, 8'h06);
    chk("R9", "no erase", mem_op_erase, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (mem_op_start) chk("R8", "start repeated", 1, 0);
    end
    chk("R8", "busy length", n, CL);
    chk("R8", "go cleared", reg_rdata, 8'h04);
  endtask

  task automatic t_hold();
    wr(8'h06);
    wr(8'hD4);
    chk("R6", "busy kept", busy, 1);
    chk("R12", "sel frozen rdata", reg_rdata, 8'h06);
    chk("R12", "space frozen", mem_space, 0);
    wr(8'h0E);
    chk("R12", "err writable while busy", reg_rdata, 8'h0E);
    wr(8'h06);
    wait_idle();
    chk("R8", "idle after hold", busy, 0);
  endtask

  task automatic t_erase();
    wr(8'h94);
    wr(8'h96);
    chk("R9", "erase strobe", mem_op_erase, 1);
    chk("R2", "prog space", mem_space, 1);
    wait_idle();
    chk("R9", "erase bit cleared", reg_rdata, 8'h84);
  endtask

  task automatic t_abort();
    wr(8'h96);
    @(negedge clk);
    warm();
    chk("R10", "busy dropped", busy, 0);
    chk("R10", "err kept sel", reg_rdata, 8'h98);
  endtask

  task automatic t_warm_idle();
    wr(8'hD4);
    warm();
    chk("R11", "idle warm", reg_rdata, 8'hD0);
    wr(8'h5C);
    warm();
    chk("R11", "idle warm keeps err", reg_rdata, 8'h58);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_space();
    t_read();
    t_gate();
    t_cycle();
    t_hold();
    t_erase();
    t_abort();
    t_warm_idle();
    wr(8'hDF);
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule